// File: doc/BRIEF.md
# Paged DMA Address and Count Engine

This block is the address and count datapath of one DMA channel. Software loads a 16-bit starting offset, a 16-bit count and an 8-bit page. After that, every transfer step moves the offset by one and takes one from the count. The engine builds a 24-bit physical address from the page and the offset. It flags the step that finishes the block and reports how much of the transfer is left.

A channel is either byte-wide or word-wide. A byte channel reaches 64 KB per page. A word channel reaches 128 KB per page: the whole address moves up by one bit and the lowest page bit is dropped. The offset counter wraps inside its page and never carries into the page register. To move on to the next page, software rewrites the page alone. At the end of a block the channel either masks itself or, in auto-initialize mode, reloads its starting offset and count and carries on.

All state sits in registers. The outputs come from one more register stage after the state, so every effect of an input shows at the ports two rising edges after that input is applied.

Top module: `dma_xfer_engine`

## Requirements
- R1: After synchronous reset, physical address is 0, the terminal-count pulse is low, the transfer residue is 1, the byte residue is 1 and the channel is masked.
- R2: On a byte channel (`word_chan_i`=0), physical address bits 23:16 equal the page and bits 15:0 equal the current offset.
- R3: On a word channel (`word_chan_i`=1), physical address bits 23:17 equal page bits 7:1, bits 16:1 equal the current offset, and bit 0 is always 0. Page bit 0 has no effect.
- R4: A step with `mode_dec_i`=0 adds one to the offset. The offset wraps from 0xFFFF to 0x0000 and the page does not change.
- R5: A step with `mode_dec_i`=1 takes one from the offset. The offset wraps from 0x0000 to 0xFFFF and the page does not change.
- R6: Each accepted step takes one from the current count. The transfer residue output is the current count plus one, taken modulo 65536.
- R7: The terminal-count output pulses high for exactly one cycle for the step that takes the count from 0x0000 to 0xFFFF. The residue reads 0 in that cycle.
- R8: When auto-initialize is off (`mode_auto_i`=0), the terminal-count step masks the channel. While the channel is masked, steps change neither the offset nor the count. `arm_i` clears the mask.
- R9: When auto-initialize is on (`mode_auto_i`=1), the cycle after the terminal-count step reloads the offset and the count from the last values written. The channel stays unmasked, and a step in that reload cycle is ignored.
- R10: Writing the page alone changes only the page. The current offset and count are kept.
- R11: The byte residue equals twice the transfer residue on a word channel, and equals the transfer residue on a byte channel.
- R12: A write to the offset or the count in the same cycle as a step takes priority. The written values are loaded and the step has no effect on either counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_addr_i | input | 1 | Load `wdata_i` into the base and current offset |
| wr_count_i | input | 1 | Load `wdata_i` into the base and current count |
| wr_page_i | input | 1 | Load `page_i` into the page register |
| wdata_i | input | 16 | Offset or count value to load |
| page_i | input | 8 | Page value to load |
| mode_dec_i | input | 1 | 1: offset counts down on a step |
| mode_auto_i | input | 1 | 1: reload on terminal count instead of masking |
| word_chan_i | input | 1 | 1: word channel, 0: byte channel |
| arm_i | input | 1 | Clear the channel mask |
| step_i | input | 1 | One-cycle transfer-step strobe |
| phys_addr_o | output | 24 | Physical bus address |
| tc_o | output | 1 | Terminal-count pulse |
| residue_o | output | 16 | Transfers left (count plus one, modulo 65536) |
| residue_bytes_o | output | 17 | Bytes left |
| masked_o | output | 1 | Channel mask state |

## Verification
Inputs applied before rising edge k change the state at edge k. The outputs show that change at edge k+1, so every result is due two rising edges after its stimulus. The terminal-count pulse, the reload and the mask change all follow this same timing. The bench drives inputs on the falling edge and updates an independent model of the channel at that moment. It queues the model's expected outputs stamped with the cycle two rising edges later. A monitor compares each queued entry at the falling edge of that cycle and flags any entry that was not compared in time.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;
  typedef struct packed {
    logic dec;
    logic autoinit;
  } xfer_mode_t;

  typedef enum logic {
    CHAN_BYTE = 1'b0,
    CHAN_WORD = 1'b1
  } chan_kind_t;
endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
  import dma_xfer_pkg::*;
#(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [OFS_W-1:0] wdata,
  input  logic             reload,
  input  logic             step,
  input  xfer_mode_t       mode,
  output logic [OFS_W-1:0] cur_o
);
  localparam logic [OFS_W-1:0] ONE = {{(OFS_W-1){1'b0}}, 1'b1};

  logic [OFS_W-1:0] base_q;
  logic [OFS_W-1:0] cur_q;

  // offset wraps inside its page; no carry leaves this counter
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cur_q  <= '0;
    end else if (wr) begin
      base_q <= wdata;
      cur_q  <= wdata;
    end else if (reload) begin
      cur_q  <= base_q;
    end else if (step) begin
      cur_q  <= mode.dec ? cur_q - ONE : cur_q + ONE;
    end
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/dma_count_unit.sv
module dma_count_unit #(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [OFS_W-1:0] wdata,
  input  logic             reload,
  input  logic             step,
  output logic [OFS_W-1:0] cur_o,
  output logic [OFS_W-1:0] base_o,
  output logic             zero_o,
  output logic [OFS_W-1:0] residue_o
);
  localparam logic [OFS_W-1:0] ONE = {{(OFS_W-1){1'b0}}, 1'b1};

  logic [OFS_W-1:0] base_q;
  logic [OFS_W-1:0] cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cur_q  <= '0;
    end else if (wr) begin
      base_q <= wdata;
      cur_q  <= wdata;
    end else if (reload) begin
      cur_q  <= base_q;
    end else if (step) begin
      cur_q  <= cur_q - ONE;
    end
  end

  assign cur_o     = cur_q;
  assign base_o    = base_q;
  assign zero_o    = (cur_q == '0);
  assign residue_o = cur_q + ONE;
endmodule

// File: rtl/dma_phys_map.sv
module dma_phys_map #(
  parameter int PAGE_W = 8,
  parameter int OFS_W  = 16
) (
  input  logic [PAGE_W-1:0]       page,
  input  logic [OFS_W-1:0]        ofs,
  input  logic                    word,
  input  logic [OFS_W-1:0]        residue,
  output logic [PAGE_W+OFS_W-1:0] phys,
  output logic [OFS_W:0]          residue_bytes
);
  localparam int PHYS_W = PAGE_W + OFS_W;

  logic [PHYS_W-1:0] byte_addr;
  logic [PHYS_W-1:0] word_addr;

  assign byte_addr = {page, ofs};

  generate
    if (PAGE_W > 1) begin : g_wide_page
      assign word_addr = {page[PAGE_W-1:1], ofs, 1'b0};
    end else begin : g_narrow_page
      assign word_addr = {ofs, 1'b0};
    end
  endgenerate

  assign phys          = word ? word_addr : byte_addr;
  assign residue_bytes = word ? {residue, 1'b0} : {1'b0, residue};
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_xfer_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFS_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_addr_i,
  input  logic                    wr_count_i,
  input  logic                    wr_page_i,
  input  logic [OFS_W-1:0]        wdata_i,
  input  logic [PAGE_W-1:0]       page_i,
  input  logic                    mode_dec_i,
  input  logic                    mode_auto_i,
  input  logic                    word_chan_i,
  input  logic                    arm_i,
  input  logic                    step_i,
  output logic [PAGE_W+OFS_W-1:0] phys_addr_o,
  output logic                    tc_o,
  output logic [OFS_W-1:0]        residue_o,
  output logic [OFS_W:0]          residue_bytes_o,
  output logic                    masked_o
);
  localparam int PHYS_W = PAGE_W + OFS_W;
  localparam logic [OFS_W-1:0] RES_RST = {{(OFS_W-1){1'b0}}, 1'b1};

  xfer_mode_t       mode;
  chan_kind_t       kind_q;
  logic             word_q;
  logic [PAGE_W-1:0] page_q;
  logic             mask_q;
  logic             pend_q;
  logic             tc_q;
  logic             step_go;
  logic             tc_hit;
  logic [OFS_W-1:0] ofs_cur;
  logic [OFS_W-1:0] cnt_cur;
  logic [OFS_W-1:0] cnt_base;
  logic             cnt_zero;
  logic [OFS_W-1:0] res_w;
  logic [PHYS_W-1:0] phys_w;
  logic [OFS_W:0]   resb_w;

  logic [PHYS_W-1:0] phys_q;
  logic [OFS_W-1:0]  res_q;
  logic [OFS_W:0]    resb_q;
  logic              tc_out_q;
  logic              mask_out_q;

  assign mode    = '{dec: mode_dec_i, autoinit: mode_auto_i};
  assign step_go = step_i && !mask_q && !pend_q && !wr_addr_i && !wr_count_i;
  assign tc_hit  = step_go && cnt_zero;
  assign word_q  = (kind_q == CHAN_WORD);

  dma_addr_unit #(.OFS_W(OFS_W)) addr_u (
    .clk    (clk),
    .rst    (rst),
    .wr     (wr_addr_i),
    .wdata  (wdata_i),
    .reload (pend_q),
    .step   (step_go),
    .mode   (mode),
    .cur_o  (ofs_cur)
  );

  dma_count_unit #(.OFS_W(OFS_W)) cnt_u (
    .clk       (clk),
    .rst       (rst),
    .wr        (wr_count_i),
    .wdata     (wdata_i),
    .reload    (pend_q),
    .step      (step_go),
    .cur_o     (cnt_cur),
    .base_o    (cnt_base),
    .zero_o    (cnt_zero),
    .residue_o (res_w)
  );

  // channel control: page, channel kind, mask, pending reload
  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      kind_q <= CHAN_BYTE;
      mask_q <= 1'b1;
      pend_q <= 1'b0;
      tc_q   <= 1'b0;
    end else begin
      if (wr_page_i) page_q <= page_i;
      kind_q <= word_chan_i ? CHAN_WORD : CHAN_BYTE;
      tc_q   <= tc_hit;
      pend_q <= tc_hit && mode.autoinit;
      if (tc_hit && !mode.autoinit) mask_q <= 1'b1;
      else if (arm_i)               mask_q <= 1'b0;
    end
  end

  dma_phys_map #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) map_u (
    .page          (page_q),
    .ofs           (ofs_cur),
    .word          (word_q),
    .residue       (res_w),
    .phys          (phys_w),
    .residue_bytes (resb_w)
  );

  // output register stage
  always_ff @(posedge clk) begin
    if (rst) begin
      phys_q     <= '0;
      res_q      <= RES_RST;
      resb_q     <= {1'b0, RES_RST};
      tc_out_q   <= 1'b0;
      mask_out_q <= 1'b1;
    end else begin
      phys_q     <= phys_w;
      res_q      <= res_w;
      resb_q     <= resb_w;
      tc_out_q   <= tc_q;
      mask_out_q <= mask_q;
    end
  end

  assign phys_addr_o     = phys_q;
  assign residue_o       = res_q;
  assign residue_bytes_o = resb_q;
  assign tc_o            = tc_out_q;
  assign masked_o        = mask_out_q;
endmodule

// File: rtl/dma_xfer_checker.sv
module dma_xfer_checker #(
  parameter int PAGE_W = 8,
  parameter int OFS_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              tc_o,
  input logic [OFS_W-1:0]  residue_o,
  input logic              phys0,
  input logic              word_q,
  input logic              mask_q,
  input logic              pend_q,
  input logic              wr_count_i,
  input logic              wr_page_i,
  input logic [OFS_W-1:0]  cnt_cur,
  input logic [OFS_W-1:0]  cnt_base,
  input logic [PAGE_W-1:0] page_q
);
  AST_TC_RESIDUE_ZERO: assert property (@(posedge clk) disable iff (rst)
    tc_o |-> residue_o == '0); // R7
  AST_TC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    tc_o |=> !tc_o); // R7
  AST_WORD_LSB_LOW: assert property (@(posedge clk) disable iff (rst)
    word_q |=> !phys0); // R3
  AST_MASKED_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mask_q && !pend_q && !wr_count_i) |=> $stable(cnt_cur)); // R8
  AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !wr_count_i) |=> cnt_cur == $past(cnt_base)); // R9
  AST_AUTO_UNMASKED: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> !mask_q); // R9
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_page_i |=> $stable(page_q)); // R10
endmodule

bind dma_xfer_engine dma_xfer_checker #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .tc_o       (tc_o),
  .residue_o  (residue_o),
  .phys0      (phys_addr_o[0]),
  .word_q     (word_q),
  .mask_q     (mask_q),
  .pend_q     (pend_q),
  .wr_count_i (wr_count_i),
  .wr_page_i  (wr_page_i),
  .cnt_cur    (cnt_cur),
  .cnt_base   (cnt_base),
  .page_q     (page_q)
);

// File: tb/dma_xfer_engine_tb_top.sv
`timescale 1ns/1ps
module dma_xfer_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_addr = 1'b0, wr_count = 1'b0, wr_page = 1'b0;
  logic [15:0] wdata = '0;
  logic [7:0]  page_in = '0;
  logic        dec = 1'b0, aut = 1'b0, word = 1'b0, arm = 1'b0, step = 1'b0;
  logic [23:0] phys;
  logic        tc;
  logic [15:0] res;
  logic [16:0] resb;
  logic        msk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int          due;
    logic [23:0] phys;
    logic [15:0] res;
    logic [16:0] resb;
    logic        tc;
    logic        msk;
    string       tag;
  } exp_t;
  exp_t sb[$];

  // reference model state
  logic [15:0] m_ba = '0, m_a = '0, m_bc = '0, m_c = '0;
  logic [7:0]  m_page = '0;
  logic        m_mask = 1'b1, m_pend = 1'b0, m_word = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dma_xfer_engine dut_i (
    .clk(clk), .rst(rst),
    .wr_addr_i(wr_addr), .wr_count_i(wr_count), .wr_page_i(wr_page),
    .wdata_i(wdata), .page_i(page_in),
    .mode_dec_i(dec), .mode_auto_i(aut), .word_chan_i(word),
    .arm_i(arm), .step_i(step),
    .phys_addr_o(phys), .tc_o(tc), .residue_o(res),
    .residue_bytes_o(resb), .masked_o(msk)
  );

  // driver: update model from requirements, queue expectation due two edges later
  task automatic tick(input string tag);
    logic go, tch;
    exp_t e;
    go  = step && !m_mask && !m_pend && !wr_addr && !wr_count; // R8 R9 R12
    tch = go && (m_c == 16'h0000);                             // R7
    if (wr_page) m_page = page_in;                             // R10
    if (wr_addr) begin m_ba = wdata; m_a = wdata; end
    else if (m_pend) m_a = m_ba;                               // R9
    else if (go) m_a = dec ? m_a - 16'd1 : m_a + 16'd1;        // R4 R5
    if (wr_count) begin m_bc = wdata; m_c = wdata; end
    else if (m_pend) m_c = m_bc;
    else if (go) m_c = m_c - 16'd1;                            // R6
    if (tch && !aut) m_mask = 1'b1;
    else if (arm) m_mask = 1'b0;
    m_pend = tch && aut;
    m_word = word;
    e.due  = cyc + 2;
    e.phys = m_word ? {m_page[7:1], m_a, 1'b0} : {m_page, m_a}; // R2 R3
    e.res  = m_c + 16'd1;
    e.resb = m_word ? {e.res, 1'b0} : {1'b0, e.res};           // R11
    e.tc   = tch;
    e.msk  = m_mask;
    e.tag  = tag;
    sb.push_back(e);
    @(negedge clk);
    wr_addr = 1'b0; wr_count = 1'b0; wr_page = 1'b0; arm = 1'b0; step = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      while (sb.size() > 0 && sb[0].due < cyc) begin
        total++; bad++;
        $display("FAIL %s: result not compared at due cycle %0d (now %0d)", sb[0].tag, sb[0].due, cyc);
        void'(sb.pop_front());
      end
      if (sb.size() > 0 && sb[0].due == cyc) begin
        exp_t e;
        e = sb.pop_front();
        total++;
        if (phys !== e.phys || res !== e.res || resb !== e.resb || tc !== e.tc || msk !== e.msk) begin
          bad++;
          $display("FAIL %s: actual phys=%h res=%h resb=%h tc=%b msk=%b expected phys=%h res=%h resb=%h tc=%b msk=%b",
                   e.tag, phys, res, resb, tc, msk, e.phys, e.res, e.resb, e.tc, e.msk);
        end
      end
    end
  end

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    total++;
    if (phys !== 24'h0 || tc !== 1'b0 || res !== 16'h1 || resb !== 17'h1 || msk !== 1'b1) begin
      bad++;
      $display("FAIL R1: actual phys=%h tc=%b res=%h resb=%h msk=%b expected 000000 0 0001 00001 1",
               phys, tc, res, resb, msk);
    end

    // byte channel, increment, offset wrap without page carry
    wr_page = 1; page_in = 8'h12; wr_addr = 1; wdata = 16'hFFFE; tick("R2 load");
    wr_count = 1; wdata = 16'd3; tick("R6 load count");
    arm = 1; tick("R8 arm");
    step = 1; tick("R4 step");
    step = 1; tick("R4 wrap");
    step = 1; tick("R6 step");
    step = 1; tick("R7 terminal");
    step = 1; tick("R8 masked step");
    idle("R8 hold", 2);

    // write priority over step
    arm = 1; tick("R12 arm");
    step = 1; wr_addr = 1; wdata = 16'h4000; tick("R12 write wins");
    step = 1; tick("R12 step after write");

    // word channel, decrement, page bit 0 ignored
    word = 1; dec = 1; wr_page = 1; page_in = 8'h35; wr_addr = 1; wdata = 16'h0001; tick("R3 load");
    wr_count = 1; wdata = 16'd1; tick("R11 load count");
    step = 1; tick("R5 step");
    step = 1; tick("R5 wrap terminal");
    idle("R3 hold", 2);

    // auto-initialize
    word = 0; dec = 0; aut = 1;
    wr_addr = 1; wdata = 16'h0100; tick("R9 load");
    wr_count = 1; wdata = 16'd1; arm = 1; tick("R9 load count");
    step = 1; tick("R9 step");
    step = 1; tick("R9 terminal");
    step = 1; tick("R9 reload cycle step ignored");
    step = 1; tick("R9 step after reload");
    idle("R9 hold", 2);

    // page-only reload keeps offset
    aut = 0;
    wr_page = 1; page_in = 8'h7F; tick("R10 page only");
    step = 1; tick("R10 step in new page");
    word = 1; tick("R11 word view");
    idle("R10 drain", 3);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual run still busy expected finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule